// File: doc/BRIEF.md
# Processor Mode and Stack-Pointer Controller

This block keeps track of whether a small processor core runs application code (thread mode) or services an exception (handler mode), and selects which of two stack pointers is active. Out of reset the core is in thread mode and uses the process stack pointer. When an interrupt request passes the priority mask, the block runs a stacking sequence through a one-access-per-cycle memory port. It pushes a fixed return code and then the current process stack pointer onto the main stack. It then enters handler mode, switches to the main stack pointer and presents the handler vector address for one cycle.

A return request in handler mode runs the reverse sequence. The process stack pointer and the return code are popped from the main stack, the main stack pointer is restored and the block goes back to thread mode. An 8-bit priority threshold holds off low-priority requests in thread mode. The threshold is cleared on entry, kept in a shadow register and restored on return. Writes to the control registers (threshold, main and process stack pointers) are privileged. In thread mode such a write is refused and raises a fault pulse.

Top module: `mode_stack_ctrl`

## Requirements
- R1: After reset the block is in thread mode (`handler_mode`=0), `busy`=0, `msp`=MSP_INIT, `psp`=PSP_INIT, `pri_mask`=0 and `priv_fault`=0.
- R2: Only an accepted exception moves thread mode to handler mode, and only a return request moves handler mode to thread mode. `exc_req` is ignored in handler mode and `ret_req` is ignored in thread mode.
- R3: `sp_active` equals `psp` in thread mode and `msp` in handler mode.
- R4: On entry the block first writes RET_CODE to address MSP-4 and then writes the current PSP to MSP-8. Each write completes only in a cycle with `mem_rdy`=1. It then leaves MSP at its old value minus 8 and sets handler mode.
- R5: After both pushes, `vec_valid` is high for exactly one cycle with `vec_addr` = VEC_BASE + 4 x `exc_num` (the number sampled when the request is accepted).
- R6: On return the block reads the word at MSP into PSP and adds 4 to MSP. It then reads the next word (the return code) and adds 4 again, then re-enters thread mode.
- R7: In thread mode and idle, a request with `exc_pri` >= `pri_mask` is accepted (unsigned compare, so mask 0 accepts all). A request with a lower priority is held off and starts no sequence.
- R8: The live threshold is cleared on entry, its old value saved in a shadow register, and restored from the shadow on return. A threshold write in handler mode updates the shadow, so `pri_mask` stays 0 until return.
- R9: `ctl_sel` encodes 0 = threshold, 1 = MSP, 2 = PSP, 3 = none. In handler mode a write takes effect one cycle later. In thread mode it changes nothing and `priv_fault` is high for the single following cycle.
- R10: `busy` is high from the cycle after acceptance until the sequence ends. `exc_req`, `ret_req` and `ctl_we` arriving while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request (level) |
| exc_num | input | NUM_W | Exception number |
| exc_pri | input | PRI_W | Request priority |
| ret_req | input | 1 | Exception return request |
| ctl_we | input | 1 | Privileged control register write |
| ctl_sel | input | 2 | Control register select |
| ctl_wdata | input | ADDR_W | Control write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | ADDR_W | Memory write data |
| mem_rdata | input | ADDR_W | Memory read data |
| mem_rdy | input | 1 | Access completes this cycle |
| handler_mode | output | 1 | 1 = handler mode |
| busy | output | 1 | Entry or return sequence running |
| sp_active | output | ADDR_W | Active stack pointer |
| msp | output | ADDR_W | Main stack pointer |
| psp | output | ADDR_W | Process stack pointer |
| pri_mask | output | PRI_W | Live priority threshold |
| vec_valid | output | 1 | Handler address valid pulse |
| vec_addr | output | ADDR_W | Handler address |
| priv_fault | output | 1 | Refused privileged write pulse |

## Verification
The main sweep sets a range of thresholds (0, 1, 37, 128, 255) and offers every priority from 0 to 255 against each of them. This separates correct acceptance from off-by-one and signed compare errors at the threshold edge. Each accepted request runs a full entry and return under memory stalls of 0, 1 and 3 cycles. The bench rewrites the stacked process pointer before each return, so a missing pop, a wrong stacking order or a wrong offset shows up. Separate patterns cover thread-mode privileged writes, a return request in thread mode, a request in handler mode, and requests and writes issued during a running sequence.

// File: rtl/msc_pkg.sv
package msc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_E_CODE = 3'd1,
        ST_E_PSP  = 3'd2,
        ST_E_VEC  = 3'd3,
        ST_R_PSP  = 3'd4,
        ST_R_CODE = 3'd5
    } seq_state_e;

    localparam logic [1:0] SEL_MASK = 2'd0;
    localparam logic [1:0] SEL_MSP  = 2'd1;
    localparam logic [1:0] SEL_PSP  = 2'd2;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/msc_mask.sv
module msc_mask #(
    parameter int unsigned PRI_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             handler_i,
    input  logic             entry_go_i,
    input  logic             ret_done_i,
    input  logic             shadow_wr_i,
    input  logic [PRI_W-1:0] shadow_wdata_i,
    input  logic [PRI_W-1:0] exc_pri_i,
    output logic             gate_ok_o,
    output logic [PRI_W-1:0] mask_o
);

    typedef struct packed {
        logic [PRI_W-1:0] live;
        logic [PRI_W-1:0] shadow;
    } mask_regs_t;

    mask_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (entry_go_i) begin
            r_d.shadow = r_q.live;
            r_d.live   = '0;
        end
        if (shadow_wr_i) begin
            r_d.shadow = shadow_wdata_i;
        end
        if (ret_done_i) begin
            r_d.live = r_q.shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_ok_o = (exc_pri_i >= r_q.live);
    assign mask_o    = r_q.live;

    AST_MASK_ZERO_IN_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        handler_i |-> (r_q.live == '0)); // R8

    AST_ACCEPT_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        entry_go_i |-> (exc_pri_i >= r_q.live)); // R7

    AST_RESTORE_FROM_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done_i |=> (r_q.live == $past(r_q.shadow))); // R8

endmodule

// File: rtl/msc_vec.sv
module msc_vec #(
    parameter int unsigned             ADDR_W   = 32,
    parameter int unsigned             NUM_W    = 6,
    parameter logic [ADDR_W-1:0]       VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_go_i,
    input  logic [NUM_W-1:0]  exc_num_i,
    output logic [ADDR_W-1:0] vec_addr_o
);

    localparam int unsigned SHIFT = $clog2(msc_pkg::WORD_BYTES);

    typedef struct packed {
        logic [NUM_W-1:0] num;
    } vec_regs_t;

    vec_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (entry_go_i) begin
            r_d.num = exc_num_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign vec_addr_o = VEC_BASE + (ADDR_W'(r_q.num) << SHIFT);

endmodule

// File: rtl/msc_seq.sv
module msc_seq
    import msc_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] MSP_INIT = '0,
    parameter logic [ADDR_W-1:0] PSP_INIT = '0,
    parameter logic [ADDR_W-1:0] RET_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req_i,
    input  logic              gate_ok_i,
    input  logic              ret_req_i,
    input  logic              ctl_we_i,
    input  logic [1:0]        ctl_sel_i,
    input  logic [ADDR_W-1:0] ctl_wdata_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [ADDR_W-1:0] mem_wdata_o,
    input  logic [ADDR_W-1:0] mem_rdata_i,
    input  logic              mem_rdy_i,
    output logic              entry_go_o,
    output logic              ret_done_o,
    output logic              shadow_wr_o,
    output logic              handler_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] sp_active_o,
    output logic [ADDR_W-1:0] msp_o,
    output logic [ADDR_W-1:0] psp_o,
    output logic              vec_valid_o,
    output logic              fault_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        seq_state_e        state;
        logic              handler;
        logic [ADDR_W-1:0] msp;
        logic [ADDR_W-1:0] psp;
        logic              fault;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.fault   = 1'b0;
        entry_go_o  = 1'b0;
        ret_done_o  = 1'b0;
        shadow_wr_o = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (!r_q.handler && exc_req_i && gate_ok_i) begin
                    entry_go_o = 1'b1;
                    r_d.state  = ST_E_CODE;
                end else if (r_q.handler && ret_req_i) begin
                    r_d.state = ST_R_PSP;
                end else if (ctl_we_i) begin
                    if (!r_q.handler) begin
                        r_d.fault = 1'b1;
                    end else begin
                        unique case (ctl_sel_i)
                            SEL_MASK: shadow_wr_o = 1'b1;
                            SEL_MSP:  r_d.msp     = ctl_wdata_i;
                            SEL_PSP:  r_d.psp     = ctl_wdata_i;
                            default:  ;
                        endcase
                    end
                end
            end
            ST_E_CODE: begin
                if (mem_rdy_i) begin
                    r_d.msp   = r_q.msp - STEP;
                    r_d.state = ST_E_PSP;
                end
            end
            ST_E_PSP: begin
                if (mem_rdy_i) begin
                    r_d.msp     = r_q.msp - STEP;
                    r_d.handler = 1'b1;
                    r_d.state   = ST_E_VEC;
                end
            end
            ST_E_VEC: begin
                r_d.state = ST_IDLE;
            end
            ST_R_PSP: begin
                if (mem_rdy_i) begin
                    r_d.psp   = mem_rdata_i;
                    r_d.msp   = r_q.msp + STEP;
                    r_d.state = ST_R_CODE;
                end
            end
            ST_R_CODE: begin
                if (mem_rdy_i) begin
                    r_d.msp     = r_q.msp + STEP;
                    r_d.handler = 1'b0;
                    ret_done_o  = 1'b1;
                    r_d.state   = ST_IDLE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.handler <= 1'b0;
            r_q.msp     <= MSP_INIT;
            r_q.psp     <= PSP_INIT;
            r_q.fault   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = r_q.msp;
        mem_wdata_o = r_q.psp;
        unique case (r_q.state)
            ST_E_CODE: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.msp - STEP;
                mem_wdata_o = RET_CODE;
            end
            ST_E_PSP: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = r_q.msp - STEP;
            end
            ST_R_PSP, ST_R_CODE: begin
                mem_req_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign handler_o   = r_q.handler;
    assign busy_o      = (r_q.state != ST_IDLE);
    assign sp_active_o = r_q.handler ? r_q.msp : r_q.psp;
    assign msp_o       = r_q.msp;
    assign psp_o       = r_q.psp;
    assign vec_valid_o = (r_q.state == ST_E_VEC);
    assign fault_o     = r_q.fault;

    AST_ENTER_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.handler) |-> ($past(r_q.state) == ST_E_PSP)); // R2

    AST_LEAVE_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.handler) |-> ($past(r_q.state) == ST_R_CODE)); // R2

    AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_rdy_i) |=> (r_q.msp == $past(r_q.msp) - STEP)); // R4

    AST_FIRST_PUSH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) && !r_q.handler |-> (mem_we_o && mem_wdata_o == RET_CODE)); // R4

    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.fault |-> (r_q.msp == $past(r_q.msp)) && (r_q.psp == $past(r_q.psp)) && !r_q.handler); // R9

    AST_VEC_IN_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> r_q.handler && $past(r_q.state) == ST_E_PSP); // R5

endmodule

// File: rtl/mode_stack_ctrl.sv
module mode_stack_ctrl #(
    parameter int unsigned       ADDR_W   = 32,
    parameter int unsigned       NUM_W    = 6,
    parameter int unsigned       PRI_W    = 8,
    parameter logic [ADDR_W-1:0] MSP_INIT = 32'h0000_0100,
    parameter logic [ADDR_W-1:0] PSP_INIT = 32'h0000_0080,
    parameter logic [ADDR_W-1:0] VEC_BASE = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] RET_CODE = 32'hFFFF_FFF5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [NUM_W-1:0]  exc_num,
    input  logic [PRI_W-1:0]  exc_pri,
    input  logic              ret_req,
    input  logic              ctl_we,
    input  logic [1:0]        ctl_sel,
    input  logic [ADDR_W-1:0] ctl_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic              handler_mode,
    output logic              busy,
    output logic [ADDR_W-1:0] sp_active,
    output logic [ADDR_W-1:0] msp,
    output logic [ADDR_W-1:0] psp,
    output logic [PRI_W-1:0]  pri_mask,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              priv_fault
);

    logic entry_go;
    logic ret_done;
    logic shadow_wr;
    logic gate_ok;

    msc_seq #(
        .ADDR_W   (ADDR_W),
        .MSP_INIT (MSP_INIT),
        .PSP_INIT (PSP_INIT),
        .RET_CODE (RET_CODE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .exc_req_i   (exc_req),
        .gate_ok_i   (gate_ok),
        .ret_req_i   (ret_req),
        .ctl_we_i    (ctl_we),
        .ctl_sel_i   (ctl_sel),
        .ctl_wdata_i (ctl_wdata),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .mem_rdy_i   (mem_rdy),
        .entry_go_o  (entry_go),
        .ret_done_o  (ret_done),
        .shadow_wr_o (shadow_wr),
        .handler_o   (handler_mode),
        .busy_o      (busy),
        .sp_active_o (sp_active),
        .msp_o       (msp),
        .psp_o       (psp),
        .vec_valid_o (vec_valid),
        .fault_o     (priv_fault)
    );

    msc_mask #(
        .PRI_W (PRI_W)
    ) u_mask (
        .clk            (clk),
        .rst_n          (rst_n),
        .handler_i      (handler_mode),
        .entry_go_i     (entry_go),
        .ret_done_i     (ret_done),
        .shadow_wr_i    (shadow_wr),
        .shadow_wdata_i (ctl_wdata[PRI_W-1:0]),
        .exc_pri_i      (exc_pri),
        .gate_ok_o      (gate_ok),
        .mask_o         (pri_mask)
    );

    msc_vec #(
        .ADDR_W   (ADDR_W),
        .NUM_W    (NUM_W),
        .VEC_BASE (VEC_BASE)
    ) u_vec (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry_go_i (entry_go),
        .exc_num_i  (exc_num),
        .vec_addr_o (vec_addr)
    );

endmodule

// File: tb/test_mode_stack_ctrl.sv
module test_mode_stack_ctrl;

    localparam logic [31:0] MSP0 = 32'h0000_0100;
    localparam logic [31:0] PSP0 = 32'h0000_0080;
    localparam logic [31:0] VBASE = 32'h0000_1000;
    localparam logic [31:0] RCODE = 32'hFFFF_FFF5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [5:0]  exc_num = '0;
    logic [7:0]  exc_pri = '0;
    logic        ret_req = 1'b0;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_sel = '0;
    logic [31:0] ctl_wdata = '0;
    logic        mem_req, mem_we, mem_rdy;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        handler_mode, busy, vec_valid, priv_fault;
    logic [31:0] sp_active, msp, psp, vec_addr;
    logic [7:0]  pri_mask;

    logic [31:0] mem [64];
    int          stall = 0;
    int          wcnt = 0;
    logic        poke_en = 1'b0;
    logic [5:0]  poke_idx = '0;
    logic [31:0] poke_val = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int vec_cnt;
    logic [31:0] vec_seen;

    always #10 clk = ~clk;

    mode_stack_ctrl #(
        .MSP_INIT (MSP0), .PSP_INIT (PSP0), .VEC_BASE (VBASE), .RET_CODE (RCODE)
    ) i_mode_stack_ctrl (
        .clk (clk), .rst_n (rst_n), .exc_req (exc_req), .exc_num (exc_num),
        .exc_pri (exc_pri), .ret_req (ret_req), .ctl_we (ctl_we), .ctl_sel (ctl_sel),
        .ctl_wdata (ctl_wdata), .mem_req (mem_req), .mem_we (mem_we),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .mem_rdy (mem_rdy), .handler_mode (handler_mode), .busy (busy),
        .sp_active (sp_active), .msp (msp), .psp (psp), .pri_mask (pri_mask),
        .vec_valid (vec_valid), .vec_addr (vec_addr), .priv_fault (priv_fault)
    );

    assign mem_rdy   = mem_req && (wcnt >= stall);
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (mem_req && !mem_rdy) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (mem_req && mem_rdy && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        if (poke_en) mem[poke_idx] <= poke_val;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            errors = errors + 1;
            $display("FAIL R10 watchdog expired: act %0d cycles exp < 190000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // waits for a running sequence to end, counting vector pulses
    task automatic wait_idle();
        vec_cnt  = 0;
        vec_seen = '0;
        for (int i = 0; i < 200 && busy; i++) begin
            if (vec_valid) begin
                vec_cnt  = vec_cnt + 1;
                vec_seen = vec_addr;
            end
            tick();
        end
        chk("R10 sequence ends", {31'd0, busy}, 32'd0);
    endtask

    task automatic do_entry(input logic [5:0] num, input logic [7:0] pri, output logic acc);
        exc_req = 1'b1; exc_num = num; exc_pri = pri;
        tick();
        exc_req = 1'b0;
        acc = busy;
        if (acc) wait_idle();
    endtask

    task automatic do_return();
        ret_req = 1'b1;
        tick();
        ret_req = 1'b0;
        chk("R10 busy on return", {31'd0, busy}, 32'd1);
        wait_idle();
    endtask

    task automatic ctl_write(input logic [1:0] sel, input logic [31:0] val);
        ctl_we = 1'b1; ctl_sel = sel; ctl_wdata = val;
        tick();
        ctl_we = 1'b0;
    endtask

    // full entry/return round trip with stacked-pointer rewrite
    task automatic round_trip(input logic [5:0] num, input logic [7:0] pri,
                              input logic [7:0] m, input logic [31:0] new_psp);
        logic [31:0] m0, p0;
        logic acc;
        m0 = msp; p0 = psp;
        do_entry(num, pri, acc);
        chk("R7 accept when pri>=mask", {31'd0, acc}, {31'd0, pri >= m});
        if (acc) begin
            chk("R2 handler after entry", {31'd0, handler_mode}, 32'd1);
            chk("R4 code at msp-4", mem[6'((m0 - 32'd4) >> 2)], RCODE);
            chk("R4 psp at msp-8", mem[6'((m0 - 32'd8) >> 2)], p0);
            chk("R4 msp after pushes", msp, m0 - 32'd8);
            chk("R3 active sp in handler", sp_active, m0 - 32'd8);
            chk("R5 one vector pulse", vec_cnt, 32'd1);
            chk("R5 vector address", vec_seen, VBASE + 32'(num) * 32'd4);
            chk("R8 mask cleared in handler", {24'd0, pri_mask}, 32'd0);
            poke_en = 1'b1; poke_idx = 6'((m0 - 32'd8) >> 2); poke_val = new_psp;
            tick();
            poke_en = 1'b0;
            do_return();
            chk("R6 psp popped", psp, new_psp);
            chk("R6 msp restored", msp, m0);
            chk("R2 thread after return", {31'd0, handler_mode}, 32'd0);
            chk("R3 active sp in thread", sp_active, new_psp);
            chk("R8 mask restored", {24'd0, pri_mask}, {24'd0, m});
        end else begin
            chk("R7 held off stays thread", {31'd0, handler_mode}, 32'd0);
        end
    endtask

    initial begin
        logic acc;
        logic [7:0] masks [5];
        int stalls [3];
        logic [31:0] m0;
        masks[0] = 8'd0; masks[1] = 8'd1; masks[2] = 8'd37; masks[3] = 8'd128; masks[4] = 8'd255;
        stalls[0] = 0; stalls[1] = 1; stalls[2] = 3;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 thread mode", {31'd0, handler_mode}, 32'd0);
        chk("R1 busy low", {31'd0, busy}, 32'd0);
        chk("R1 msp", msp, MSP0);
        chk("R1 psp", psp, PSP0);
        chk("R1 mask", {24'd0, pri_mask}, 32'd0);
        chk("R1 fault", {31'd0, priv_fault}, 32'd0);
        chk("R3 reset active sp", sp_active, PSP0);

        // R9 privileged writes refused in thread mode
        for (int s = 0; s < 4; s++) begin
            ctl_write(2'(s), 32'h0000_0044);
            chk("R9 fault pulse", {31'd0, priv_fault}, 32'd1);
            chk("R9 msp untouched", msp, MSP0);
            chk("R9 psp untouched", psp, PSP0);
            chk("R9 mask untouched", {24'd0, pri_mask}, 32'd0);
            tick();
            chk("R9 fault one cycle", {31'd0, priv_fault}, 32'd0);
        end

        // R2 return request in thread mode ignored
        ret_req = 1'b1; tick(); ret_req = 1'b0;
        chk("R2 ret in thread ignored busy", {31'd0, busy}, 32'd0);
        chk("R2 ret in thread ignored mode", {31'd0, handler_mode}, 32'd0);

        // main sweep: stalls x thresholds x all priorities
        for (int si = 0; si < 3; si++) begin
            stall = stalls[si];
            for (int mi = 0; mi < 5; mi++) begin
                // enter, set saved threshold, request in handler ignored, return
                m0 = msp;
                do_entry(6'd1, 8'd255, acc);
                chk("R7 top priority accepted", {31'd0, acc}, 32'd1);
                exc_req = 1'b1; exc_pri = 8'd255; tick(); exc_req = 1'b0;
                chk("R2 exc in handler ignored", {31'd0, busy}, 32'd0);
                ctl_write(2'd0, {24'd0, masks[mi]});
                chk("R8 shadow write keeps live 0", {24'd0, pri_mask}, 32'd0);
                chk("R9 no fault in handler", {31'd0, priv_fault}, 32'd0);
                ctl_write(2'd2, 32'h0000_0ABC);
                chk("R9 psp write in handler", psp, 32'h0000_0ABC);
                do_return();
                chk("R8 mask after set", {24'd0, pri_mask}, {24'd0, masks[mi]});
                chk("R6 msp back", msp, m0);
                for (int p = 0; p < 256; p++) begin
                    round_trip(6'(p), 8'(p), masks[mi], 32'h40 + 32'(p % 16) * 4);
                end
            end
        end

        // R10 inputs during a running sequence are ignored
        stall = 2;
        ctl_write(2'd1, 32'h0); // thread: refused
        tick();
        m0 = msp;
        exc_req = 1'b1; exc_num = 6'd9; exc_pri = 8'd255;
        tick();
        chk("R10 busy after accept", {31'd0, busy}, 32'd1);
        exc_num = 6'd3; ret_req = 1'b1; ctl_we = 1'b1; ctl_sel = 2'd1; ctl_wdata = 32'h10;
        wait_idle();
        exc_req = 1'b0; ret_req = 1'b0; ctl_we = 1'b0;
        chk("R10 vector uses sampled number", vec_seen, VBASE + 32'd36);
        chk("R10 msp not overwritten", msp, m0 - 32'd8);
        chk("R10 still handler", {31'd0, handler_mode}, 32'd1);
        tick();
        chk("R10 no further sequence", {31'd0, busy}, 32'd0);
        ctl_write(2'd1, m0 - 32'd8);
        chk("R9 msp write in handler", msp, m0 - 32'd8);
        do_return();
        chk("R2 back to thread", {31'd0, handler_mode}, 32'd0);
        chk("R6 msp final", msp, m0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule